// File: doc/BRIEF.md
# Strobed handshake port controller

This block holds the handshake state for one 8-bit parallel port group that moves data under strobe control. It works in one of two directions, chosen by a mode input. In the input direction, a peripheral pulls its strobe low to load the port pins into a receive register. This raises an input-full flag, and once the strobe is released it may raise an interrupt request to the CPU. In the output direction, a CPU write loads a transmit register and drives an active-low output-full flag. The peripheral's acknowledge releases that flag and may raise an interrupt.

The CPU read and write strobes are active low and synchronous to the block clock. The peripheral strobe and acknowledge are asynchronous. Each passes through a synchroniser chain of `SYNC_STAGES` flops before the logic acts on it. A single interrupt-enable flag gates the request. That flag changes only through an explicit bit set/reset command. All state is updated on rising clock edges and uses a synchronous, active-high reset.

Top module: `strobe_port_ctl`

## Requirements
- R1: While `rst` is high, on every clock edge, `ibf` and `intr` go to 0, `obf_n` goes to 1, the interrupt enable clears, and `cpu_rdata` and `port_out` go to 0.
- R2: In input mode (`dir_out`=0), `stb_n` held low is first seen `SYNC_STAGES` clock edges later. On the next edge after that, `ibf` becomes 1 and `cpu_rdata` takes the value of `port_in`. `ibf` is still 0 when only `SYNC_STAGES` edges have passed.
- R3: In input mode, `ibf` clears on the first clock edge at which `cpu_rd_n` is seen high after being low. If the synchronised strobe is still low at that edge, `ibf` stays 1.
- R4: In input mode, `intr` is set when the synchronised strobe is high, `ibf` is 1, the interrupt enable is 1 and no read is in progress. `intr` never sets while the strobe is low. `intr` clears on the clock edge at which `cpu_rd_n` is first seen low.
- R5: In output mode (`dir_out`=1), `port_out` takes `cpu_wdata` on every edge where `cpu_wr_n` is low. On the edge where `cpu_wr_n` is first seen high again, `obf_n` goes to 0.
- R6: In output mode, the synchronised `ack_n` being low sets `obf_n` to 1 on the next edge. A write ending on that same edge takes priority for that one cycle.
- R7: In output mode, `intr` is set when the synchronised acknowledge is high, `obf_n` is 1, the interrupt enable is 1 and no write is in progress. `intr` clears on the edge at which `cpu_wr_n` is first seen low.
- R8: The interrupt enable changes only on an edge with `inte_we`=1, where it takes `inte_val`. While the enable is 0, `intr` is 0 from the next edge on.
- R9: In output mode, strobes have no effect on `ibf` or `cpu_rdata`. In input mode, writes and acknowledges have no effect on `obf_n` or `port_out`.
- R10: A change of `dir_out` clears `intr`. The request is then set again from the new direction's own condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_out | input | 1 | Direction: 0 input, 1 output |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| port_in | input | W | Port pins sampled in input mode |
| port_out | output | W | Latched output data to the peripheral |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_wdata | input | W | CPU write data |
| cpu_rdata | output | W | Latched input data for the CPU |
| inte_we | input | 1 | Bit set/reset command strobe for the interrupt enable |
| inte_val | input | 1 | Value written to the interrupt enable |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request |

## Verification
The bench builds the block with `W`=8 and `SYNC_STAGES`=3. Three synchroniser stages mean the latency check of R2 tests a chain longer than the default. A wrong stage count or a missing stage would show up as `ibf` rising one cycle early or late. Eight data bits let random pin and write values expose a capture on the wrong edge or in the wrong direction. Directed cases cover a strobe held low across a CPU read and an acknowledge held low across a write.

// File: rtl/strobe_port_ctl.sv
module strobe_port_ctl #(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_out,
  input  logic         stb_n,
  input  logic         ack_n,
  input  logic [W-1:0] port_in,
  output logic [W-1:0] port_out,
  input  logic         cpu_rd_n,
  input  logic         cpu_wr_n,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  input  logic         inte_we,
  input  logic         inte_val,
  output logic         ibf,
  output logic         obf_n,
  output logic         intr
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] stb_sh, ack_sh;
  logic          rd_q, wr_q, dir_q, inte;

  wire stb_s    = stb_sh[LAST];
  wire ack_s    = ack_sh[LAST];
  wire rd_rise  = cpu_rd_n & ~rd_q;
  wire rd_fall  = ~cpu_rd_n & rd_q;
  wire wr_rise  = cpu_wr_n & ~wr_q;
  wire wr_fall  = ~cpu_wr_n & wr_q;
  wire mode_chg = dir_out ^ dir_q;
  wire in_set   = stb_s & ibf & cpu_rd_n & rd_q;
  wire out_set  = ack_s & obf_n & cpu_wr_n & wr_q;
  wire req_clr  = dir_out ? wr_fall : rd_fall;
  wire req_set  = dir_out ? out_set : in_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_sh <= '1;
      ack_sh <= '1;
      rd_q   <= 1'b1;
      wr_q   <= 1'b1;
      dir_q  <= 1'b0;
    end else begin
      stb_sh <= {stb_sh[LAST-1:0], stb_n};
      ack_sh <= {ack_sh[LAST-1:0], ack_n};
      rd_q   <= cpu_rd_n;
      wr_q   <= cpu_wr_n;
      dir_q  <= dir_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ibf       <= 1'b0;
      cpu_rdata <= '0;
    end else if (!dir_out) begin
      if (!stb_s) begin
        ibf       <= 1'b1;
        cpu_rdata <= port_in;
      end else if (rd_rise) begin
        ibf <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obf_n    <= 1'b1;
      port_out <= '0;
    end else if (dir_out) begin
      if (!cpu_wr_n)
        port_out <= cpu_wdata;
      if (wr_rise)
        obf_n <= 1'b0;
      else if (!ack_s)
        obf_n <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      inte <= 1'b0;
    else if (inte_we)
      inte <= inte_val;
  end

  always_ff @(posedge clk) begin
    if (rst || !inte || mode_chg || req_clr)
      intr <= 1'b0;
    else if (req_set)
      intr <= 1'b1;
  end

endmodule

module strobe_port_ctl_chk (
  input logic clk,
  input logic rst,
  input logic dir_out,
  input logic cpu_rd_n,
  input logic cpu_wr_n,
  input logic stb_s,
  input logic ack_s,
  input logic inte,
  input logic inte_we,
  input logic ibf,
  input logic obf_n,
  input logic intr
);

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!ibf && obf_n && !intr && !inte));

  // R3
  ibf_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir_out && stb_s && cpu_rd_n && !$past(cpu_rd_n)) |=> !ibf);

  // R4
  in_intr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir_out && !cpu_rd_n && $past(cpu_rd_n)) |=> !intr);

  // R4
  in_intr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir_out && $past(!dir_out) && !stb_s && !intr) |=> !intr);

  // R5
  obf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_out && cpu_wr_n && !$past(cpu_wr_n)) |=> !obf_n);

  // R6
  obf_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_out && !ack_s && !(cpu_wr_n && !$past(cpu_wr_n))) |=> obf_n);

  // R7
  out_intr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_out && !cpu_wr_n && $past(cpu_wr_n)) |=> !intr);

  // R8
  inte_gate_chk: assert property (@(posedge clk) disable iff (rst) !inte |=> !intr);

  // R8
  inte_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(inte) |-> $past(inte_we));

  // R10
  mode_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_out != $past(dir_out)) |=> !intr);

endmodule

bind strobe_port_ctl strobe_port_ctl_chk chk_i (
  .clk(clk), .rst(rst), .dir_out(dir_out), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
  .stb_s(stb_s), .ack_s(ack_s), .inte(inte), .inte_we(inte_we),
  .ibf(ibf), .obf_n(obf_n), .intr(intr)
);

// File: tb/strobe_port_ctl_tb_top.sv
module strobe_port_ctl_tb_top;
  localparam int W  = 8;
  localparam int NS = 3;
  localparam int SETTLE = NS + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_out = 1'b0, stb_n = 1'b1, ack_n = 1'b1;
  logic cpu_rd_n = 1'b1, cpu_wr_n = 1'b1, inte_we = 1'b0, inte_val = 1'b0;
  logic [W-1:0] port_in = '0, cpu_wdata = '0;
  logic [W-1:0] port_out, cpu_rdata;
  logic ibf, obf_n, intr;

  int unsigned checks = 0, fails = 0;
  bit done = 1'b0;

  bit e_dir = 1'b0, e_ibf = 1'b0, e_obf_n = 1'b1, e_inte = 1'b0;
  logic [W-1:0] e_rdata = '0, e_out = '0;

  always #5 clk = ~clk;

  strobe_port_ctl #(.W(W), .SYNC_STAGES(NS)) dut_i (
    .clk(clk), .rst(rst), .dir_out(dir_out), .stb_n(stb_n), .ack_n(ack_n),
    .port_in(port_in), .port_out(port_out), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .inte_we(inte_we), .inte_val(inte_val),
    .ibf(ibf), .obf_n(obf_n), .intr(intr)
  );

  function automatic bit exp_intr();
    return e_inte & (e_dir ? e_obf_n : e_ibf);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk(ibf == e_ibf, {req, " ibf"}, int'(ibf), int'(e_ibf));
    chk(obf_n == e_obf_n, {req, " obf_n"}, int'(obf_n), int'(e_obf_n));
    chk(intr == exp_intr(), {req, " intr"}, int'(intr), int'(exp_intr()));
    chk(cpu_rdata == e_rdata, {req, " cpu_rdata"}, int'(cpu_rdata), int'(e_rdata));
    chk(port_out == e_out, {req, " port_out"}, int'(port_out), int'(e_out));
  endtask

  task automatic do_strobe(input logic [W-1:0] d);
    port_in = d; stb_n = 1'b0; tick(SETTLE);
    stb_n = 1'b1; tick(SETTLE);
    if (!e_dir) begin e_ibf = 1'b1; e_rdata = d; end
    check_all(e_dir ? "R9 strobe ignored" : "R2 strobe");
  endtask

  task automatic do_read();
    cpu_rd_n = 1'b0; tick(2);
    if (!e_dir) begin
      chk(intr == 1'b0, "R4 intr cleared by read", int'(intr), 0);
      chk(ibf == e_ibf, "R3 ibf held during read", int'(ibf), int'(e_ibf));
    end
    cpu_rd_n = 1'b1; tick(2);
    if (!e_dir) e_ibf = 1'b0;
    check_all("R3 read");
  endtask

  task automatic do_write(input logic [W-1:0] d);
    cpu_wdata = d; cpu_wr_n = 1'b0; tick(2);
    if (e_dir) chk(intr == 1'b0, "R7 intr cleared by write", int'(intr), 0);
    cpu_wr_n = 1'b1; tick(2);
    if (e_dir) begin e_obf_n = 1'b0; e_out = d; end
    check_all(e_dir ? "R5 write" : "R9 write ignored");
  endtask

  task automatic do_ack();
    ack_n = 1'b0; tick(SETTLE);
    ack_n = 1'b1; tick(SETTLE);
    if (e_dir) e_obf_n = 1'b1;
    check_all(e_dir ? "R6 ack" : "R9 ack ignored");
  endtask

  task automatic do_inte(input bit v);
    inte_val = v; inte_we = 1'b1; tick(1);
    inte_we = 1'b0; inte_val = ~v; tick(2);
    e_inte = v;
    check_all("R8 enable");
  endtask

  task automatic do_mode(input bit m);
    dir_out = m; tick(1);
    if (m != e_dir) chk(intr == 1'b0, "R10 intr cleared on mode change", int'(intr), 0);
    tick(2);
    e_dir = m;
    check_all("R10 mode");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd20240611);
    tick(4);
    rst = 1'b0;
    tick(1);
    check_all("R1 reset");

    // R2 latency: ibf rises exactly NS+1 edges after strobe low
    do_inte(1'b1);
    port_in = 8'hA5; stb_n = 1'b0;
    tick(NS);
    chk(ibf == 1'b0, "R2 ibf not yet set", int'(ibf), 0);
    tick(1);
    chk(ibf == 1'b1, "R2 ibf set after sync", int'(ibf), 1);
    chk(cpu_rdata == 8'hA5, "R2 data latched", int'(cpu_rdata), 'hA5);
    tick(3);
    chk(intr == 1'b0, "R4 no intr while strobe low", int'(intr), 0);
    cpu_rd_n = 1'b0; tick(2); cpu_rd_n = 1'b1; tick(2);
    chk(ibf == 1'b1, "R3 ibf kept with strobe low", int'(ibf), 1);
    stb_n = 1'b1; tick(SETTLE);
    e_ibf = 1'b1; e_rdata = 8'hA5;
    check_all("R4 intr after strobe release");
    do_read();

    // R6 ack held low across a write
    do_mode(1'b1);
    ack_n = 1'b0; tick(SETTLE);
    cpu_wdata = 8'h3C; cpu_wr_n = 1'b0; tick(2); cpu_wr_n = 1'b1;
    tick(1);
    chk(obf_n == 1'b0, "R6 write wins for one cycle", int'(obf_n), 0);
    tick(1);
    chk(obf_n == 1'b1, "R6 ack low releases obf_n", int'(obf_n), 1);
    ack_n = 1'b1; tick(SETTLE);
    e_out = 8'h3C; e_obf_n = 1'b1;
    check_all("R7 intr after ack");
    do_inte(1'b0);
    do_inte(1'b1);

    for (int i = 0; i < 500; i++) begin
      case ($urandom_range(0, 6))
        0: do_strobe(W'($urandom));
        1: do_read();
        2: do_write(W'($urandom));
        3: do_ack();
        4: do_inte(1'($urandom));
        5: do_mode(1'($urandom));
        default: begin tick(3); check_all("R8 idle"); end
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule